// File: doc/BRIEF.md
# Two-Thread Decode Slot Arbiter with Resource Throttling

This block picks, every clock cycle, which of two hardware threads may use the single decode slot of a core. Each thread carries a 3-bit priority set by software. Priority 0 stops the thread. Priority 1 is the lowest running level and 7 is the highest. When the two priorities differ, the higher thread gets most of the slots. The share it gets grows with the size of the gap. When both priorities are equal, the slots alternate. A separate mode hands every slot to one chosen thread.

On top of the priority share, the block balances shared resources. For each thread it watches three inputs: the completion-table occupancy, the number of outstanding L2 misses, and a flag that marks a long-latency instruction in flight. A thread that holds too many completion entries drops one priority level. A thread with too many misses is kept from decoding. A thread that starts a long-latency instruction gets a one-cycle flush request for its not-yet-dispatched work, and it is kept from decoding while the flag stays high. When both threads sit at the lowest priority in two-thread mode, the block signals low power and grants decode only once every 32 cycles.

All outputs are registered. A grant reflects the priority and mode inputs sampled at the previous clock edge. It also reflects the throttle states, which themselves were registered from the counters one edge earlier.

Top module: `smt_decode_arbiter`

## Requirements
- R1: While reset is high, dec_grant, flush_req and low_power are all zero.
- R2: A thread whose effective priority is 0 is never granted. When exactly one thread can run, that thread is granted every cycle.
- R3: In two-thread mode, when both threads can run and their effective priorities are equal, the grants alternate between the threads one cycle at a time.
- R4: Let cycle index 0 be the first cycle after reset, counting up by one per cycle. For unequal effective priorities with difference d, let N = 2^(d+1). The lower thread is granted on the cycles whose index mod N equals N-1, and the higher thread is granted on every other cycle.
- R5: With single_mode high, the thread selected by single_tid is granted every cycle when it can run. The other thread is never granted.
- R6: While a thread's completion-table throttle is engaged, its effective priority is one below its set priority. The reduction never takes a priority below 1.
- R7: While a thread's miss throttle is engaged, the thread is not granted.
- R8: A throttle engages when its count is greater than or equal to its limit. It releases only when count + 2 < limit. For counts in between, the throttle keeps its state.
- R9: When a thread's long-latency flag rises, its flush_req bit is high for exactly one cycle. The thread is not granted from the following cycle for as long as the flag stays high.
- R10: In two-thread mode with both set priorities equal to 1, low_power is high. Grants then occur only on cycles whose index mod 32 equals 31, alternating between the threads when both can run.
- R11: At most one bit of dec_grant is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| single_mode | input | 1 | 1: one thread owns every decode slot |
| single_tid | input | 1 | Thread that owns the slots in single mode |
| prio_t0 | input | 3 | Software priority of thread 0 |
| prio_t1 | input | 3 | Software priority of thread 1 |
| gct_cnt_t0 | input | 6 | Completion-table entries held by thread 0 |
| gct_cnt_t1 | input | 6 | Completion-table entries held by thread 1 |
| miss_cnt_t0 | input | 4 | Outstanding L2 misses of thread 0 |
| miss_cnt_t1 | input | 4 | Outstanding L2 misses of thread 1 |
| longlat_t0 | input | 1 | Thread 0 is executing a long-latency instruction |
| longlat_t1 | input | 1 | Thread 1 is executing a long-latency instruction |
| gct_limit | input | 6 | Completion-table occupancy limit |
| miss_limit | input | 4 | Outstanding-miss limit |
| dec_grant | output | 2 | One-hot decode grant, bit n for thread n |
| flush_req | output | 2 | One-cycle flush request, bit n for thread n |
| low_power | output | 1 | Power-save state active |

## Verification
The hardest case to reach is the hysteresis band, where a counter has fallen below its limit but not far enough to release the throttle. The stimulus walks a miss count and a completion count down one step at a time, staying at each step for several cycles, so that the held and released states can be told apart in the grant pattern. The long priority windows are also hard to reach: a gap of six needs a 128-cycle window. These are covered by holding one priority pair across a full window and counting the lower thread's grants. In the same way, low-power grants are counted across 64 cycles.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int NTHR = 2;

  typedef struct packed {
    logic gct_thr;   // occupancy throttle engaged
    logic miss_thr;  // miss throttle engaged
    logic stall;     // long-latency stop in force
    logic flush;     // one-cycle flush request
  } thr_stat_t;
endpackage

// File: rtl/smt_thr_monitor.sv
module smt_thr_monitor
  import smt_arb_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int MISS_W = 4,
  parameter int HYST   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  gct_cnt,
  input  logic [CNT_W-1:0]  gct_limit,
  input  logic [MISS_W-1:0] miss_cnt,
  input  logic [MISS_W-1:0] miss_limit,
  input  logic              longlat,
  output thr_stat_t         stat
);
  localparam logic [CNT_W:0]  HYST_G = (CNT_W+1)'(HYST);
  localparam logic [MISS_W:0] HYST_M = (MISS_W+1)'(HYST);

  logic gct_q, miss_q, stall_q, flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gct_q   <= 1'b0;
      miss_q  <= 1'b0;
      stall_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (gct_cnt >= gct_limit)
        gct_q <= 1'b1;
      else if (({1'b0, gct_cnt} + HYST_G) < {1'b0, gct_limit})
        gct_q <= 1'b0;
      if (miss_cnt >= miss_limit)
        miss_q <= 1'b1;
      else if (({1'b0, miss_cnt} + HYST_M) < {1'b0, miss_limit})
        miss_q <= 1'b0;
      stall_q <= longlat;
      flush_q <= longlat & ~stall_q;
    end
  end

  assign stat = '{gct_thr: gct_q, miss_thr: miss_q, stall: stall_q, flush: flush_q};

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    flush_q |=> !flush_q); // R9
  AST_GCT_ENGAGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (gct_q && !$past(gct_q)) |-> $past(gct_cnt >= gct_limit)); // R8
  AST_MISS_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!miss_q && $past(miss_q)) |-> $past(({1'b0, miss_cnt} + HYST_M) < {1'b0, miss_limit})); // R8
endmodule

// File: rtl/smt_share_sel.sv
module smt_share_sel #(
  parameter int PRIO_W = 3,
  parameter int SLOT_W = 7
) (
  input  logic [PRIO_W-1:0] eff_a,
  input  logic [PRIO_W-1:0] eff_b,
  input  logic [SLOT_W-1:0] slot,
  output logic              same,
  output logic              pick_b
);
  logic [PRIO_W-1:0] gap;
  logic [SLOT_W:0]   span;
  logic [SLOT_W-1:0] mask;
  logic              low_turn;

  always_comb begin
    gap      = (eff_a > eff_b) ? (eff_a - eff_b) : (eff_b - eff_a);
    span     = ({{SLOT_W{1'b0}}, 1'b1} << ({1'b0, gap} + 1'b1)) - 1'b1;
    mask     = span[SLOT_W-1:0];
    low_turn = ((slot & mask) == mask);
    same     = (eff_a == eff_b);
    pick_b   = (eff_b > eff_a) ? !low_turn : low_turn;
  end
endmodule

// File: rtl/smt_decode_arbiter.sv
module smt_decode_arbiter
  import smt_arb_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 6,
  parameter int MISS_W = 4,
  parameter int HYST   = 2,
  parameter int LP_LOG = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              single_mode,
  input  logic              single_tid,
  input  logic [PRIO_W-1:0] prio_t0,
  input  logic [PRIO_W-1:0] prio_t1,
  input  logic [CNT_W-1:0]  gct_cnt_t0,
  input  logic [CNT_W-1:0]  gct_cnt_t1,
  input  logic [MISS_W-1:0] miss_cnt_t0,
  input  logic [MISS_W-1:0] miss_cnt_t1,
  input  logic              longlat_t0,
  input  logic              longlat_t1,
  input  logic [CNT_W-1:0]  gct_limit,
  input  logic [MISS_W-1:0] miss_limit,
  output logic [1:0]        dec_grant,
  output logic [1:0]        flush_req,
  output logic              low_power
);
  localparam int PMAX   = (1 << PRIO_W) - 1;
  localparam int SLOT_W = (PMAX > LP_LOG) ? PMAX : LP_LOG;
  localparam logic [PRIO_W-1:0] P_ONE = PRIO_W'(1);

  logic [PRIO_W-1:0] prio_a [NTHR];
  logic [CNT_W-1:0]  gct_a  [NTHR];
  logic [MISS_W-1:0] miss_a [NTHR];
  logic              ll_a   [NTHR];
  thr_stat_t         st     [NTHR];
  logic [PRIO_W-1:0] eff    [NTHR];
  logic [NTHR-1:0]   run;

  assign prio_a[0] = prio_t0;   assign prio_a[1] = prio_t1;
  assign gct_a[0]  = gct_cnt_t0; assign gct_a[1] = gct_cnt_t1;
  assign miss_a[0] = miss_cnt_t0; assign miss_a[1] = miss_cnt_t1;
  assign ll_a[0]   = longlat_t0; assign ll_a[1]  = longlat_t1;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    smt_thr_monitor #(.CNT_W(CNT_W), .MISS_W(MISS_W), .HYST(HYST)) i_mon (
      .clk(clk), .rst(rst),
      .gct_cnt(gct_a[t]), .gct_limit(gct_limit),
      .miss_cnt(miss_a[t]), .miss_limit(miss_limit),
      .longlat(ll_a[t]), .stat(st[t])
    );
    assign eff[t] = (st[t].gct_thr && (prio_a[t] > P_ONE)) ? (prio_a[t] - P_ONE) : prio_a[t];
    assign run[t] = (eff[t] != '0) && !st[t].miss_thr && !st[t].stall;
  end

  logic [SLOT_W-1:0] slot_q;
  logic              rr_q, same, pick_b, lp_now, alt_used;
  logic [1:0]        g_nx, grant_q;
  logic              lp_q;

  smt_share_sel #(.PRIO_W(PRIO_W), .SLOT_W(SLOT_W)) i_share (
    .eff_a(eff[0]), .eff_b(eff[1]), .slot(slot_q), .same(same), .pick_b(pick_b)
  );

  assign lp_now = !single_mode && (prio_t0 == P_ONE) && (prio_t1 == P_ONE);

  always_comb begin
    g_nx     = '0;
    alt_used = 1'b0;
    if (single_mode) begin
      g_nx[single_tid] = run[single_tid];
    end else if (lp_now) begin
      if (&slot_q[LP_LOG-1:0]) begin
        alt_used = 1'b1;
        if (&run) g_nx[rr_q] = 1'b1;
        else      g_nx = run;
      end
    end else if (&run) begin
      if (same) begin
        alt_used   = 1'b1;
        g_nx[rr_q] = 1'b1;
      end else begin
        g_nx[pick_b] = 1'b1;
      end
    end else begin
      g_nx = run;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      lp_q    <= 1'b0;
      slot_q  <= '0;
      rr_q    <= 1'b0;
    end else begin
      grant_q <= g_nx;
      lp_q    <= lp_now;
      slot_q  <= slot_q + 1'b1;
      if (alt_used && (|g_nx)) rr_q <= ~rr_q;
    end
  end

  assign dec_grant = grant_q;
  assign low_power = lp_q;
  assign flush_req = {st[1].flush, st[0].flush};

  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec_grant)); // R11
  AST_ZERO_PRIO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(prio_t0) == '0) |-> !dec_grant[0]); // R2
  AST_MISS_BLOCKS_T1: assert property (@(posedge clk) disable iff (rst)
    $past(st[1].miss_thr) |-> !dec_grant[1]); // R7
  AST_LP_SPARSE: assert property (@(posedge clk) disable iff (rst)
    (low_power && (|dec_grant)) |-> (&$past(slot_q[LP_LOG-1:0]))); // R10
  AST_SINGLE_OTHER_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(single_mode) && !$past(single_tid)) |-> !dec_grant[1]); // R5
endmodule

// File: tb/test_smt_decode_arbiter.sv
module test_smt_decode_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       single_mode = 0, single_tid = 0;
  logic [2:0] prio_t0 = 3'd4, prio_t1 = 3'd4;
  logic [5:0] gct_cnt_t0 = 0, gct_cnt_t1 = 0, gct_limit = 6'd10;
  logic [3:0] miss_cnt_t0 = 0, miss_cnt_t1 = 0, miss_limit = 4'd5;
  logic       longlat_t0 = 0, longlat_t1 = 0;
  logic [1:0] dec_grant, flush_req;
  logic       low_power;

  smt_decode_arbiter i_smt_decode_arbiter (
    .clk(clk), .rst(rst), .single_mode(single_mode), .single_tid(single_tid),
    .prio_t0(prio_t0), .prio_t1(prio_t1),
    .gct_cnt_t0(gct_cnt_t0), .gct_cnt_t1(gct_cnt_t1),
    .miss_cnt_t0(miss_cnt_t0), .miss_cnt_t1(miss_cnt_t1),
    .longlat_t0(longlat_t0), .longlat_t1(longlat_t1),
    .gct_limit(gct_limit), .miss_limit(miss_limit),
    .dec_grant(dec_grant), .flush_req(flush_req), .low_power(low_power)
  );

  int    total = 0, bad = 0;
  string phase = "R1";
  logic [4:0] sbv [$];
  string      sbt [$];
  int g0cnt = 0, g1cnt = 0, f0cnt = 0, dbl = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, driven from the requirements
  int idx;
  bit rr;
  bit gt [2], mt [2], sl [2], rn [2], ll [2];
  int pr [2], ef [2], gc [2], mc [2];
  int d, n, lo;
  bit alt, lpn;
  logic [1:0] g, f;

  always @(posedge clk) begin
    if (rst) begin
      idx = 0; rr = 0;
      for (int t = 0; t < 2; t++) begin gt[t] = 0; mt[t] = 0; sl[t] = 0; end
    end else begin
      pr[0] = prio_t0; pr[1] = prio_t1;
      gc[0] = gct_cnt_t0; gc[1] = gct_cnt_t1;
      mc[0] = miss_cnt_t0; mc[1] = miss_cnt_t1;
      ll[0] = longlat_t0; ll[1] = longlat_t1;
      for (int t = 0; t < 2; t++) begin
        ef[t] = (gt[t] && pr[t] > 1) ? pr[t] - 1 : pr[t];
        rn[t] = (ef[t] != 0) && !mt[t] && !sl[t];
      end
      g = 2'b00; alt = 0;
      lpn = !single_mode && pr[0] == 1 && pr[1] == 1;
      if (single_mode) g[single_tid] = rn[single_tid];
      else if (lpn) begin
        if (idx % 32 == 31) begin
          alt = 1;
          if (rn[0] && rn[1]) g[rr] = 1'b1; else g = {rn[1], rn[0]};
        end
      end else if (rn[0] && rn[1]) begin
        if (ef[0] == ef[1]) begin alt = 1; g[rr] = 1'b1; end
        else begin
          d  = (ef[0] > ef[1]) ? ef[0] - ef[1] : ef[1] - ef[0];
          n  = 1 << (d + 1);
          lo = (ef[0] < ef[1]) ? 0 : 1;
          if (idx % n == n - 1) g[lo] = 1'b1; else g[1 - lo] = 1'b1;
        end
      end else g = {rn[1], rn[0]};
      f = {ll[1] && !sl[1], ll[0] && !sl[0]};
      sbv.push_back({g, f, lpn});
      sbt.push_back(phase);
      for (int t = 0; t < 2; t++) begin
        if (gc[t] >= gct_limit) gt[t] = 1; else if (gc[t] + 2 < gct_limit) gt[t] = 0;
        if (mc[t] >= miss_limit) mt[t] = 1; else if (mc[t] + 2 < miss_limit) mt[t] = 0;
        sl[t] = ll[t];
      end
      if (alt && g != 2'b00) rr = !rr;
      idx++;
    end
  end

  // monitor: pop expected item and compare against the ports
  always @(negedge clk) begin
    if (!rst && sbv.size() > 0) begin
      logic [4:0] v;
      string      t;
      v = sbv.pop_front();
      t = sbt.pop_front();
      chk(t, {dec_grant, flush_req, low_power}, v);
      g0cnt += dec_grant[0];
      g1cnt += dec_grant[1];
      f0cnt += flush_req[0];
      if (dec_grant == 2'b11) dbl++;
    end
  end

  task automatic run(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a, b;
    run(3);
    chk("R1 reset outputs", {dec_grant, flush_req, low_power}, 0);
    rst = 0;
    phase = "R3"; prio_t0 = 4; prio_t1 = 4; run(20);
    phase = "R4"; prio_t0 = 6; prio_t1 = 3; run(40);
    prio_t0 = 2; prio_t1 = 5; run(40);
    prio_t0 = 7; prio_t1 = 1; run(140);
    prio_t0 = 3; prio_t1 = 5; run(2);
    #1 a = g0cnt;
    run(128);
    #1 b = g0cnt;
    chk("R4 lower share over 128 cycles", b - a, 16);
    phase = "R2"; prio_t0 = 0; prio_t1 = 5; run(20);
    prio_t1 = 0; run(10);
    phase = "R5"; single_mode = 1; single_tid = 1; prio_t0 = 7; prio_t1 = 2; run(20);
    single_tid = 0; prio_t0 = 0; prio_t1 = 6; run(10);
    prio_t0 = 3; run(10);
    phase = "R6"; single_mode = 0; prio_t0 = 4; prio_t1 = 3; gct_cnt_t0 = 12; run(20);
    phase = "R8"; gct_cnt_t0 = 9; run(10);
    gct_cnt_t0 = 7; run(20);
    phase = "R6"; prio_t0 = 1; prio_t1 = 3; gct_cnt_t0 = 12; run(20);
    gct_cnt_t0 = 0; run(4);
    phase = "R7"; prio_t0 = 5; prio_t1 = 5; miss_cnt_t1 = 5; run(10);
    phase = "R8"; miss_cnt_t1 = 4; run(6);
    miss_cnt_t1 = 3; run(6);
    miss_cnt_t1 = 2; run(10);
    phase = "R9";
    #1 a = f0cnt;
    longlat_t0 = 1; run(6);
    longlat_t0 = 0; run(5);
    #1 b = f0cnt;
    chk("R9 single flush pulse", b - a, 1);
    phase = "R10"; prio_t0 = 1; prio_t1 = 1; run(2);
    #1 a = g0cnt + g1cnt;
    run(64);
    #1 b = g0cnt + g1cnt;
    chk("R10 sparse grants in 64 cycles", b - a, 2);
    run(10);
    chk("R11 no double grant", dbl, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule